// File: doc/BRIEF.md
# Alternating-Clock Two-Wire Frame Transmitter

This block sends one frame on a two-wire serial bus where neither line is a fixed clock. Each bit occupies one phase. In a phase, one line strobes, and the other line carries the bit. The two lines swap these roles on every bit. The receiver takes a bit on every falling edge, reading whichever line did not fall. Both lines are open-drain style: the block only pulls a line low or releases it, and a released line idles high.

A frame starts with a one-cycle start strobe, which also captures a word count. The block then emits the sync prologue and requests each 32-bit payload word through a valid/ready handshake. It shifts each word out, then appends an 8-bit XOR checksum and the closing epilogue, and finally releases the bus. A quarter-phase duration, counted in system clocks, sets all of the timing.

Top module: `tx2w_transmitter`

## Requirements
- R1: After reset and whenever no frame is in progress, both lines are released (high), and busy and ready are low.
- R2: A start strobe seen while idle raises busy on the next cycle and captures the word count. A strobe seen while busy has no effect on the waveform or the count.
- R3: The sync prologue is 22 quarters long. Line A is low and line B is high for 2 quarters. Then four repeats follow of B low for 2 quarters and B high for 2 quarters, with A still low. Then both lines are high for 2 quarters. Last, A is high and B is low for 2 quarters.
- R4: An even-numbered bit of a segment (counting from 0) uses A as the strobe and B as the data line. An odd-numbered bit swaps the two. Within each bit, quarters 0 and 1 have the strobe high and the data line at the bit value. Quarter 2 has the strobe low and the data line still at the bit value. Quarter 3 has the strobe low and the data line high.
- R5: Each word is sent from bit 31 down to bit 0. This means byte lane 3 (bits 31:24) goes first, byte lane 0 (bits 7:0) goes last, and each byte is sent most significant bit first.
- R6: Ready is high only while the block waits for the next word. While it waits, A is held high and B is held low. Ready drops on the cycle after a word is accepted and stays low while that word is shifted out.
- R7: After the last word, the block sends the 8-bit XOR of all payload bytes, MSB first, as bits 0 to 7 of its own segment. With a word count of zero, the sync is followed directly by a checksum of 0x00.
- R8: The epilogue is 13 quarters long. The first 2 quarters have both lines high. The next 4 have A high and B low. Then come 2 quarters with both low, 2 with A high and B low, 2 with both low, and 1 with A high and B low. After that, both lines are released and busy drops.
- R9: The two line outputs never change in the same clock cycle.
- R10: Every quarter lasts exactly QCLK clock cycles, and the first sync quarter begins on the cycle after the start strobe is taken.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame start strobe |
| word_count_i | input | CNT_W | Number of payload words, taken with the strobe |
| word_i | input | WORD_W | Payload word |
| word_valid_i | input | 1 | Payload word valid |
| word_ready_o | output | 1 | Block is waiting for a payload word |
| a_pull_low_o | output | 1 | Pull line A low (0 releases it high) |
| b_pull_low_o | output | 1 | Pull line B low (0 releases it high) |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with QCLK set to 2. This makes every quarter two cycles long, so a stretched or shortened quarter shows up as a mismatch on a specific cycle. The short quarters also keep a three-word frame to about a thousand cycles. The word count width and word width stay at their defaults. This brings the zero-word frame, an all-ones/all-zeros pair whose checksum cancels to zero, handshake stalls of several cycles, and a stray strobe in the middle of a frame within reach of one short run.

// File: rtl/tx2w_pkg.sv
`timescale 1ns/1ps
// Shared types and waveform tables for the alternating-clock transmitter.
// Assumes: levels are returned as {a_high, b_high}; 1 means line released.
package tx2w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_WAIT,
        ST_WORD,
        ST_CSUM,
        ST_END
    } tx_state_e;

    localparam int QIDX_W        = 5;
    localparam int SYNC_QUARTERS = 22;
    localparam int END_QUARTERS  = 13;
    localparam int BIT_QUARTERS  = 4;
    localparam int CSUM_BITS     = 8;

    // Line levels for one quarter of the sync prologue.
    function automatic logic [1:0] sync_level(input logic [QIDX_W-1:0] idx);
        logic [QIDX_W-1:0] k;
        k = idx - QIDX_W'(2);
        if (idx < QIDX_W'(2))       return 2'b01;
        else if (idx < QIDX_W'(18)) return {1'b0, k[1]};
        else if (idx < QIDX_W'(20)) return 2'b11;
        else                        return 2'b10;
    endfunction

    // Line levels for one quarter of the closing epilogue.
    function automatic logic [1:0] end_level(input logic [QIDX_W-1:0] idx);
        case (idx)
            QIDX_W'(0), QIDX_W'(1):                          return 2'b11;
            QIDX_W'(6), QIDX_W'(7), QIDX_W'(10), QIDX_W'(11): return 2'b00;
            default:                                         return 2'b10;
        endcase
    endfunction

    // Line levels for one quarter of a data bit; phase2 swaps strobe and data.
    function automatic logic [1:0] bit_level(input logic phase2,
                                             input logic bitv,
                                             input logic [1:0] q);
        logic strobe_hi;
        logic data_lvl;
        strobe_hi = (q < 2'd2);
        data_lvl  = (q == 2'd3) ? 1'b1 : bitv;
        return phase2 ? {data_lvl, strobe_hi} : {strobe_hi, data_lvl};
    endfunction

endpackage

// File: rtl/tx2w_quarter_timer.sv
`timescale 1ns/1ps
// Quarter-phase timer: counts QCLK clocks while run is high and pulses tick
// on the last clock of each quarter. Assumes run drops between segments that
// must restart from a fresh quarter.
module tx2w_quarter_timer #(
    parameter int QCLK = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QCLK > 1) ? $clog2(QCLK) : 1;
    localparam logic [CW-1:0] LAST = CW'(QCLK - 1);

    logic [CW-1:0] cnt;

    // Count clocks within a quarter; restart whenever the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + CW'(1);
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/tx2w_payload_shifter.sv
`timescale 1ns/1ps
// Payload datapath: holds the word being sent (MSB leaves first) and folds
// every accepted word into the running byte-wise XOR checksum, which is then
// shifted out MSB first. Assumes WORD_W is a multiple of 8.
module tx2w_payload_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              shift_word,
    input  logic              shift_csum,
    output logic              word_msb,
    output logic              csum_msb
);
    localparam int BYTES = WORD_W / 8;

    logic [WORD_W-1:0] shreg;
    logic [7:0]        acc;
    logic [7:0]        fold [0:BYTES];

    assign fold[0] = 8'h00;
    for (genvar g = 0; g < BYTES; g++) begin : g_fold
        assign fold[g+1] = fold[g] ^ word_in[g*8 +: 8];
    end

    // Word register: load on acceptance, shift toward the MSB per bit sent.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else if (load) shreg <= word_in;
        else if (shift_word) shreg <= {shreg[WORD_W-2:0], 1'b0};
    end

    // Checksum: clear per frame, fold each word, shift out during its segment.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= 8'h00;
        else if (load) acc <= acc ^ fold[BYTES];
        else if (shift_csum) acc <= {acc[6:0], 1'b0};
    end

    assign word_msb = shreg[WORD_W-1];
    assign csum_msb = acc[7];
endmodule

// File: rtl/tx2w_line_encoder.sv
`timescale 1ns/1ps
// Line encoder: decodes the sequencer state into the two pull-low outputs.
// Assumes qidx holds the quarter within sync/epilogue or within a bit.
module tx2w_line_encoder
    import tx2w_pkg::*;
(
    input  tx_state_e         state,
    input  logic [QIDX_W-1:0] qidx,
    input  logic              data_bit,
    input  logic              phase2,
    output logic              a_pull_low,
    output logic              b_pull_low
);
    logic [1:0] lvl;

    // Select released/pulled levels for the current segment and quarter.
    always_comb begin
        case (state)
            ST_SYNC:          lvl = sync_level(qidx);
            ST_WAIT:          lvl = 2'b10;
            ST_WORD, ST_CSUM: lvl = bit_level(phase2, data_bit, qidx[1:0]);
            ST_END:           lvl = end_level(qidx);
            default:          lvl = 2'b11;
        endcase
    end

    assign a_pull_low = ~lvl[1];
    assign b_pull_low = ~lvl[0];
endmodule

// File: rtl/tx2w_transmitter.sv
`timescale 1ns/1ps
// Frame transmitter top: sequences sync, payload words, checksum and epilogue
// on a two-wire bus whose lines swap strobe/data roles every bit. Assumes the
// word source answers ready; the bus rests at phase-1 levels while it waits.
module tx2w_transmitter
    import tx2w_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 8,
    parameter int QCLK   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  word_count_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_valid_i,
    output logic              word_ready_o,
    output logic              a_pull_low_o,
    output logic              b_pull_low_o,
    output logic              busy_o
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [QIDX_W-1:0] SYNC_LAST = QIDX_W'(SYNC_QUARTERS - 1);
    localparam logic [QIDX_W-1:0] END_LAST  = QIDX_W'(END_QUARTERS - 1);
    localparam logic [QIDX_W-1:0] BIT_LAST  = QIDX_W'(BIT_QUARTERS - 1);
    localparam logic [BIT_W-1:0]  WORD_LAST = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0]  CSUM_LAST = BIT_W'(CSUM_BITS - 1);

    tx_state_e         state;
    logic [QIDX_W-1:0] qidx;
    logic [BIT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  words_left;
    logic              tick;
    logic              run;
    logic              take_start;
    logic              accept;
    logic              bit_done;
    logic              word_msb;
    logic              csum_msb;
    logic              data_bit;

    assign take_start = (state == ST_IDLE) && start_i;
    assign accept     = (state == ST_WAIT) && word_valid_i;
    assign run        = (state != ST_IDLE) && (state != ST_WAIT);
    assign bit_done   = tick && (qidx == BIT_LAST);
    assign data_bit   = (state == ST_CSUM) ? csum_msb : word_msb;

    tx2w_quarter_timer #(.QCLK(QCLK)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    tx2w_payload_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (take_start),
        .load      (accept),
        .word_in   (word_i),
        .shift_word((state == ST_WORD) && bit_done),
        .shift_csum((state == ST_CSUM) && bit_done),
        .word_msb  (word_msb),
        .csum_msb  (csum_msb)
    );

    tx2w_line_encoder u_enc (
        .state     (state),
        .qidx      (qidx),
        .data_bit  (data_bit),
        .phase2    (bitcnt[0]),
        .a_pull_low(a_pull_low_o),
        .b_pull_low(b_pull_low_o)
    );

    // Frame sequencer: segment state, quarter index, bit index, words left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            qidx       <= '0;
            bitcnt     <= '0;
            words_left <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state      <= ST_SYNC;
                        qidx       <= '0;
                        bitcnt     <= '0;
                        words_left <= word_count_i;
                    end
                end
                ST_SYNC: begin
                    if (tick) begin
                        if (qidx == SYNC_LAST) begin
                            qidx   <= '0;
                            bitcnt <= '0;
                            state  <= (words_left == '0) ? ST_CSUM : ST_WAIT;
                        end else begin
                            qidx <= qidx + QIDX_W'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (word_valid_i) begin
                        state  <= ST_WORD;
                        qidx   <= '0;
                        bitcnt <= '0;
                    end
                end
                ST_WORD: begin
                    if (bit_done) begin
                        qidx <= '0;
                        if (bitcnt == WORD_LAST) begin
                            bitcnt     <= '0;
                            words_left <= words_left - CNT_W'(1);
                            state      <= (words_left == CNT_W'(1)) ? ST_CSUM : ST_WAIT;
                        end else begin
                            bitcnt <= bitcnt + BIT_W'(1);
                        end
                    end else if (tick) begin
                        qidx <= qidx + QIDX_W'(1);
                    end
                end
                ST_CSUM: begin
                    if (bit_done) begin
                        qidx <= '0;
                        if (bitcnt == CSUM_LAST) begin
                            bitcnt <= '0;
                            state  <= ST_END;
                        end else begin
                            bitcnt <= bitcnt + BIT_W'(1);
                        end
                    end else if (tick) begin
                        qidx <= qidx + QIDX_W'(1);
                    end
                end
                ST_END: begin
                    if (tick) begin
                        if (qidx == END_LAST) begin
                            qidx  <= '0;
                            state <= ST_IDLE;
                        end else begin
                            qidx <= qidx + QIDX_W'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o       = (state != ST_IDLE);
    assign word_ready_o = (state == ST_WAIT);
endmodule

// File: rtl/tx2w_checker.sv
`timescale 1ns/1ps
// Port-level property checker for the transmitter, attached through bind.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module tx2w_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic word_valid_i,
    input logic word_ready_o,
    input logic a_pull_low_o,
    input logic b_pull_low_o,
    input logic busy_o
);
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!a_pull_low_o && !b_pull_low_o && !word_ready_o));

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r6_ready_rest_levels: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready_o |-> (busy_o && !a_pull_low_o && b_pull_low_o));

    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && word_ready_o) |=> !word_ready_o);

    a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready_o && !word_valid_i) |=> word_ready_o);

    a_r8_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (!a_pull_low_o && !b_pull_low_o));

    a_r9_one_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !((a_pull_low_o != $past(a_pull_low_o)) && (b_pull_low_o != $past(b_pull_low_o))));
endmodule

bind tx2w_transmitter tx2w_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o),
    .a_pull_low_o(a_pull_low_o),
    .b_pull_low_o(b_pull_low_o),
    .busy_o      (busy_o)
);

// File: tb/tx2w_transmitter_bench.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle expectation queue compared on every clock.
module tx2w_transmitter_bench;
    localparam int Q = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  count = 8'd0;
    logic [31:0] word = 32'd0;
    logic        valid = 1'b0;
    logic        ready, a_low, b_low, busy;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q [$];
    string      tag_q [$];
    logic [1:0] prev_lines = 2'b00;
    logic [31:0] words [8];
    int          delays [8];
    int          stray = 0;

    always #5 clk = ~clk;

    tx2w_transmitter #(.WORD_W(32), .CNT_W(8), .QCLK(Q)) u_tx2w_transmitter (
        .clk(clk), .rst_n(rst_n), .start_i(start), .word_count_i(count),
        .word_i(word), .word_valid_i(valid), .word_ready_o(ready),
        .a_pull_low_o(a_low), .b_pull_low_o(b_low), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, expv);
        end
    endtask

    // Append n cycles of {busy, ready, a_low, b_low} built from line highs.
    task automatic push(input int n, input bit bz, input bit rd, input bit ahi, input bit bhi, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({bz, rd, ~ahi, ~bhi});
            tag_q.push_back(tag);
        end
    endtask

    // One bit: odd index in its segment uses line B as strobe.
    task automatic push_bit(input int idx, input bit v, input string tag);
        bit odd = (idx % 2) == 1;
        push(2 * Q, 1, 0, odd ? v : 1'b1, odd ? 1'b1 : v, tag);
        push(Q,     1, 0, odd ? v : 1'b0, odd ? 1'b0 : v, tag);
        push(Q,     1, 0, odd ? 1'b1 : 1'b0, odd ? 1'b0 : 1'b1, tag);
    endtask

    task automatic build_frame(input int n);
        logic [7:0] cs = 8'h00;
        push(2 * Q, 1, 0, 0, 1, "R3 R10");
        for (int r = 0; r < 4; r++) begin
            push(2 * Q, 1, 0, 0, 0, "R3 R10");
            push(2 * Q, 1, 0, 0, 1, "R3 R10");
        end
        push(2 * Q, 1, 0, 1, 1, "R3 R10");
        push(2 * Q, 1, 0, 1, 0, "R3 R10");
        for (int w = 0; w < n; w++) begin
            push(1 + delays[w], 1, 1, 1, 0, "R6");
            for (int j = 0; j < 32; j++) push_bit(j, words[w][31 - j], "R4 R5");
            for (int b = 0; b < 4; b++) cs = cs ^ words[w][8*b +: 8];
        end
        for (int j = 0; j < 8; j++) push_bit(j, cs[7 - j], "R7");
        push(2 * Q, 1, 0, 1, 1, "R8");
        push(4 * Q, 1, 0, 1, 0, "R8");
        push(2 * Q, 1, 0, 0, 0, "R8");
        push(2 * Q, 1, 0, 1, 0, "R8");
        push(2 * Q, 1, 0, 0, 0, "R8");
        push(Q,     1, 0, 1, 0, "R8");
        push(1,     0, 0, 1, 1, "R8 R1");
    endtask

    // Compare every cycle against the expectation; also R9 single-line moves.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(!((a_low != prev_lines[1]) && (b_low != prev_lines[0])), "R9",
                {30'd0, a_low, b_low}, {30'd0, prev_lines});
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({busy, ready, a_low, b_low} == e, t,
                    {28'd0, busy, ready, a_low, b_low}, {28'd0, e});
            end
        end
        prev_lines = {a_low, b_low};
    end

    task automatic run_frame(input int n);
        @(negedge clk);
        start = 1'b1;
        count = 8'(n);
        @(posedge clk);
        build_frame(n);
        @(negedge clk);
        start = 1'b0;
        count = 8'd0;
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    do @(negedge clk); while (!ready);
                    repeat (delays[i]) @(negedge clk);
                    word  = words[i];
                    valid = 1'b1;
                    @(negedge clk);
                    valid = 1'b0;
                end
            end
            begin
                if (stray > 0) begin
                    repeat (stray) @(negedge clk);
                    start = 1'b1;
                    count = 8'd7;
                    @(negedge clk);
                    start = 1'b0;
                    count = 8'd0;
                    // R2: strobe while busy leaves the frame running
                    chk(busy == 1'b1, "R2", {31'd0, busy}, 32'd1);
                end
            end
        join
        wait (exp_q.size() == 0);
        repeat (3) begin
            @(negedge clk);
            chk({busy, ready, a_low, b_low} == 4'b0000, "R1",
                {28'd0, busy, ready, a_low, b_low}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({busy, ready, a_low, b_low} == 4'b0000, "R1",
            {28'd0, busy, ready, a_low, b_low}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: one-cycle strobe raises busy next cycle (frame with zero words, R7)
        stray = 0;
        run_frame(0);
        words[0] = 32'hA5C3_0F81; delays[0] = 0;
        run_frame(1);
        words[0] = 32'h1234_5678; delays[0] = 2;
        words[1] = 32'h8000_0001; delays[1] = 0;
        words[2] = 32'hDEAD_BEEF; delays[2] = 5;
        stray = 150;
        run_frame(3);
        stray = 0;
        words[0] = 32'hFFFF_FFFF; delays[0] = 1;
        words[1] = 32'h0000_0000; delays[1] = 3;
        run_frame(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule